// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA over a two-wire slave-serial link: one serial clock and one data line. On a start request it pulls the active-low program line low for a fixed pulse. It then confirms that the target's done line has fallen and waits out the target's program latency. Next it takes image bytes from a valid/ready byte stream and shifts each one out MSB first. A last-byte marker ends the stream. The block then keeps clocking all-ones bytes until done rises, and finishes with one more all-ones byte. If done does not rise within a completion timeout, it gives up.

A request that asks for partial reconfiguration is refused at once with an "unsupported" code, and no pin moves. The block latches the outcome on pass and fail outputs with a two-bit error code, and holds it until the next accepted start. A status output gives the target's state from the synchronized done line. All delays are counted in system-clock cycles and derived from the clock frequency parameter. The serial clock half-period is a parameter in system-clock cycles.

Top module: `cfg_loader`

## Requirements
- R1: A start with the partial flag set while idle is refused: on the next cycle fail is high with error code 3, busy stays low, and neither the program line nor the serial clock moves.
- R2: Each accepted start drives the program line low for exactly ceil(PULSE_NS*CLK_MHZ/1000) cycles, which is never below 500 ns worth of cycles.
- R3: If the synchronized done line is high three cycles after the program line is released, the run stops with fail and error code 1, and no serial clock is produced.
- R4: The first serial clock rise comes no earlier than ceil(LATENCY_NS*CLK_MHZ/1000) cycles after the program line is released. With the first byte waiting, it comes exactly that many cycles plus 4 plus CLK_DIV after the release.
- R5: Each byte gives eight serial clock rises, MSB first. Each half-period lasts CLK_DIV cycles. The data line changes only while the serial clock is low.
- R6: The byte input is ready only in the data phase while the shifter is idle and no last-marked byte has been taken. It is never ready while the serial clock is high.
- R7: If done is high when the data stream ends, exactly one 0xFF byte follows, and then pass is set with error code 0.
- R8: While done is low after the data, 0xFF bytes are shifted and done is checked after each byte. Once done is seen high, exactly one further 0xFF byte is shifted, and then pass is set with error code 0.
- R9: Byte boundaries after the data lie 16*CLK_DIV+2 cycles apart, starting at 0 cycles when the data ends. At the first boundary where done is low and at least timeout_i cycles have passed, the run stops with fail and error code 2. So ceil(timeout_i/(16*CLK_DIV+2)) fill bytes are sent.
- R10: in_reset_o equals the inverse of done_i delayed by two clock cycles.
- R11: A start request while busy has no effect on the running sequence or its result.
- R12: After reset the program line is high, the serial clock is low, and busy, pass, fail and ready are low with error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| partial_i | input | 1 | Partial-reconfiguration flag of the start request |
| timeout_i | input | TMO_W | Completion timeout in cycles |
| byte_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte valid |
| byte_last_i | input | 1 | Marks the final image byte |
| byte_ready_o | output | 1 | Byte accepted when high with valid |
| prog_n_o | output | 1 | Active-low program line to the target |
| done_i | input | 1 | Target done line, asynchronous |
| sclk_o | output | 1 | Serial configuration clock |
| sdat_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| pass_o | output | 1 | Last run completed |
| fail_o | output | 1 | Last run failed or was refused |
| err_code_o | output | 2 | 0 none, 1 done stuck, 2 timeout, 3 unsupported |
| in_reset_o | output | 1 | Target reads as in reset (synchronized done low) |

## Verification
The in-line assertions check these properties on every cycle: the program pulse never falls short of 500 ns, and no serial clock rises before the latency has passed since release. The data line holds while the clock is high, and each byte gives eight clock rises. Ready is never high during a clock-high phase, and a refused request leaves the pins quiet. Only the bench scenarios can show the byte-level results. These are the MSB-first order of the image bytes, the exact number of trailing all-ones bytes for each done arrival point, and the fill-byte count at each timeout value. The bench sweeps these against arithmetic expectations.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_CHECK, S_LAT, S_DATA, S_POST, S_WAIT
  } state_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_STUCK = 2'd1,
    ERR_TMO   = 2'd2,
    ERR_UNSUP = 2'd3
  } err_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[0] <= 1'b0;
          else         ff_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[i] <= 1'b0;
          else         ff_q[i] <= ff_q[i-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfg_cnt.sv
module cfg_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // saturating so long waits never wrap
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (en_i && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       sdat_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(DIV - 1);

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic          hi_q;
  logic          busy_q;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= 8'hFF;
      bit_q  <= '0;
      hi_q   <= 1'b0;
      busy_q <= 1'b0;
      div_q  <= '0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= byte_i;
        busy_q <= 1'b1;
        hi_q   <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
      end
    end else if (div_q == DIV_END) begin
      div_q <= '0;
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        // falling edge: advance data so it settles before the next rise
        hi_q <= 1'b0;
        if (bit_q == 3'd7) busy_q <= 1'b0;
        else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b1};
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = busy_q & hi_q;
  assign sdat_o = busy_q ? sh_q[7] : 1'b1;

  // checker state: serial clock rises per byte
  logic       sclk_d;
  logic [3:0] rises_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      rises_q <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (load_i && !busy_q)        rises_q <= '0;
      else if (sclk_o && !sclk_d)   rises_q <= rises_q + 4'd1;
    end

  a_r5_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));
  a_r5_eight_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> rises_q == 4'd8);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader import cfg_pkg::*; #(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned PULSE_NS   = 1000,
  parameter int unsigned LATENCY_NS = 7_500_000,
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned TMO_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  input  logic             byte_last_i,
  output logic             byte_ready_o,
  output logic             prog_n_o,
  input  logic             done_i,
  output logic             sclk_o,
  output logic             sdat_o,
  output logic             busy_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic [1:0]       err_code_o,
  output logic             in_reset_o
);
  localparam longint unsigned PULSE_CYC = (64'(PULSE_NS) * 64'(CLK_MHZ) + 64'd999) / 64'd1000;
  localparam longint unsigned MIN_PULSE = (64'd500 * 64'(CLK_MHZ) + 64'd999) / 64'd1000;
  localparam longint unsigned LAT_CYC   = (64'(LATENCY_NS) * 64'(CLK_MHZ) + 64'd999) / 64'd1000;
  localparam longint unsigned SYNC_WAIT = 64'd3;
  localparam longint unsigned PH_MAX    = (PULSE_CYC > LAT_CYC) ?
                                          ((PULSE_CYC > SYNC_WAIT) ? PULSE_CYC : SYNC_WAIT) :
                                          ((LAT_CYC > SYNC_WAIT) ? LAT_CYC : SYNC_WAIT);
  localparam int unsigned PH_W = $clog2(PH_MAX + 64'd1);
  localparam logic [PH_W-1:0] PULSE_END = PH_W'(PULSE_CYC - 64'd1);
  localparam logic [PH_W-1:0] CHK_END   = PH_W'(SYNC_WAIT - 64'd1);
  localparam logic [PH_W-1:0] LAT_END   = PH_W'(LAT_CYC - 64'd1);

  state_t st_q, st_d;
  err_t   code_q, code_d;
  logic   pass_q, fail_q, last_q, final_q;
  logic   set_pass, set_fail, clr_res;

  logic            done_s;
  logic [PH_W-1:0] ph_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic            sh_load, sh_busy;
  logic [7:0]      sh_byte;
  logic            accept, tmo_hit;

  cfg_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (done_i), .q_o (done_s)
  );

  cfg_cnt #(.W(PH_W)) u_phase (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (st_d != st_q), .en_i (1'b1), .cnt_o (ph_cnt)
  );

  // elapsed cycles since the end of the image data
  cfg_cnt #(.W(TMO_W)) u_tmo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i ((st_q != S_POST) && (st_q != S_WAIT)),
    .en_i  (1'b1), .cnt_o (tmo_cnt)
  );

  cfg_shift #(.DIV(CLK_DIV)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (sh_load), .byte_i (sh_byte),
    .busy_o (sh_busy), .sclk_o (sclk_o), .sdat_o (sdat_o)
  );

  assign byte_ready_o = (st_q == S_DATA) && !sh_busy && !last_q;
  assign accept       = byte_valid_i && byte_ready_o;
  assign tmo_hit      = tmo_cnt >= timeout_i;

  always_comb begin
    st_d     = st_q;
    code_d   = code_q;
    sh_load  = 1'b0;
    sh_byte  = 8'hFF;
    set_pass = 1'b0;
    set_fail = 1'b0;
    clr_res  = 1'b0;
    unique case (st_q)
      S_IDLE:
        if (start_i) begin
          if (partial_i) begin
            set_fail = 1'b1;
            code_d   = ERR_UNSUP;
          end else begin
            clr_res = 1'b1;
            code_d  = ERR_NONE;
            st_d    = S_PULSE;
          end
        end
      S_PULSE: if (ph_cnt == PULSE_END) st_d = S_CHECK;
      S_CHECK:
        if (ph_cnt == CHK_END) begin
          if (done_s) begin
            set_fail = 1'b1;
            code_d   = ERR_STUCK;
            st_d     = S_IDLE;
          end else begin
            st_d = S_LAT;
          end
        end
      S_LAT: if (ph_cnt == LAT_END) st_d = S_DATA;
      S_DATA: begin
        sh_byte = byte_i;
        sh_load = accept;
        if (last_q && !sh_busy) st_d = S_POST;
      end
      S_POST:
        if (done_s || !tmo_hit) begin
          sh_load = 1'b1;
          st_d    = S_WAIT;
        end else begin
          set_fail = 1'b1;
          code_d   = ERR_TMO;
          st_d     = S_IDLE;
        end
      S_WAIT:
        if (!sh_busy) begin
          if (final_q) begin
            set_pass = 1'b1;
            st_d     = S_IDLE;
          end else begin
            st_d = S_POST;
          end
        end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      code_q  <= ERR_NONE;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      last_q  <= 1'b0;
      final_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      if (clr_res)       begin pass_q <= 1'b0; fail_q <= 1'b0; end
      else if (set_pass) pass_q <= 1'b1;
      else if (set_fail) begin pass_q <= 1'b0; fail_q <= 1'b1; end
      if (st_q != S_DATA)                last_q <= 1'b0;
      else if (accept && byte_last_i)    last_q <= 1'b1;
      if (st_q == S_IDLE)                final_q <= 1'b0;
      else if (st_q == S_POST && done_s) final_q <= 1'b1;
    end
  end

  assign prog_n_o   = (st_q != S_PULSE);
  assign busy_o     = (st_q != S_IDLE);
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign err_code_o = code_q;
  assign in_reset_o = !done_s;

  // checker state: program low width and cycles since release
  logic [PH_W-1:0] pw_q, since_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pw_q    <= '0;
      since_q <= '0;
    end else begin
      if (prog_n_o) pw_q <= '0;
      else if (pw_q != '1) pw_q <= pw_q + 1'b1;
      if (!prog_n_o) since_q <= '0;
      else if (since_q != '1) since_q <= since_q + 1'b1;
    end

  a_r1_unsup_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && partial_i && !busy_o) |=> (fail_o && err_code_o == 2'd3 && !busy_o && prog_n_o && !sclk_o));
  a_r2_pulse_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_n_o) |-> 64'(pw_q) >= MIN_PULSE);
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> 64'(since_q) >= LAT_CYC);
  a_r6_ready_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !sclk_o);
  a_r3_stuck_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && err_code_o == 2'd1) |-> (!sclk_o && prog_n_o));
  a_r12_result_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int CLK_MHZ = 250, PULSE_NS = 1000, LATENCY_NS = 800, DIV = 2, TW = 16;
  localparam int PULSE_EXP = 250;   // 1000 ns at 250 MHz
  localparam int LAT_EXP   = 200;   // 800 ns at 250 MHz
  localparam int PER       = 16 * DIV + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, partial = 0, bvalid = 0, blast = 0;
  logic [7:0] bdata = 0;
  logic [TW-1:0] tmo = '1;
  logic ready, prog_n, sclk, sdat, busy, pass, fail, inrst, done_w;
  logic [1:0] code;

  int  checks = 0, fails = 0;
  int  bitcnt = 0, base = 0, done_at = 0;
  bit  arm = 0, done_force = 0;
  logic bits [0:4095];
  int  pw_run = 0, last_pw = 0, pulses = 0, since = 0, last_gap = -1, ready_bad = 0;
  bit  gap_open = 0;
  logic sclk_prev = 0;

  assign done_w = done_force | (arm && ((bitcnt - base) >= done_at));

  cfg_loader #(.CLK_MHZ(CLK_MHZ), .PULSE_NS(PULSE_NS), .LATENCY_NS(LATENCY_NS),
               .CLK_DIV(DIV), .TMO_W(TW)) u_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .partial_i(partial), .timeout_i(tmo),
    .byte_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(ready),
    .prog_n_o(prog_n), .done_i(done_w), .sclk_o(sclk), .sdat_o(sdat), .busy_o(busy),
    .pass_o(pass), .fail_o(fail), .err_code_o(code), .in_reset_o(inrst));

  always @(negedge clk) begin
    if (!prog_n) pw_run++;
    else if (pw_run != 0) begin
      last_pw = pw_run; pulses++; pw_run = 0; since = 0; gap_open = 1;
    end else since++;
    if (ready && sclk) ready_bad++;
    if (sclk && !sclk_prev) begin
      if (bitcnt < 4096) bits[bitcnt] = sdat;
      bitcnt++;
      if (gap_open) begin last_gap = since; gap_open = 0; end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int j);
    return 8'((s * 37 + j * 91 + 5) & 255);
  endfunction

  task automatic pulse_start(input bit part);
    @(negedge clk); start = 1; partial = part;
    @(negedge clk); start = 0; partial = 0;
  endtask

  task automatic feed(input int n, input int s);
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      bdata = pat(s, j); blast = (j == n - 1); bvalid = 1;
      while (!ready) @(negedge clk);
      @(negedge clk);
    end
    bvalid = 0; blast = 0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!(pass || fail) && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic check_bits(input int n, input int s, input int extra, input string req);
    int total = 8 * (n + extra);
    chk((bitcnt - base) == total, req, bitcnt - base, total);
    if ((bitcnt - base) == total)
      for (int i = 0; i < n + extra; i++) begin
        logic [7:0] v = 0;
        logic [7:0] e = (i < n) ? pat(s, i) : 8'hFF;
        for (int b = 0; b < 8; b++) v = {v[6:0], bits[base + 8 * i + b]};
        chk(v == e, req, int'(v), int'(e));
      end
  endtask

  // d_at < 0 leaves done low for the whole run
  task automatic run_load(input int n, input int s, input int d_at, input int t,
                          input int extra, input int ecode, input bit inj);
    int p0 = pulses;
    base = bitcnt; done_force = 0; arm = (d_at >= 0); done_at = d_at; tmo = TW'(t);
    pulse_start(0);
    fork
      feed(n, s);
      wait_result();
      if (inj) begin
        repeat (40) @(negedge clk);
        start = 1; partial = 1; @(negedge clk); start = 0; partial = 0;
      end
    join
    chk(pulses == p0 + 1 && last_pw == PULSE_EXP, "R2 pulse width", last_pw, PULSE_EXP);
    chk(last_gap == LAT_EXP + 4 + DIV, "R4 release to first clock", last_gap, LAT_EXP + 4 + DIV);
    if (ecode == 0) begin
      chk(pass && !fail && code == 2'd0, inj ? "R11 start while busy" : "R7 R8 pass", int'(code), 0);
      check_bits(n, s, extra, extra == 1 ? "R7 R5 bit stream" : "R8 R5 bit stream");
    end else begin
      chk(fail && !pass && code == 2'(ecode), "R9 timeout code", int'(code), ecode);
      check_bits(n, s, extra, "R9 fill bytes");
    end
    arm = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(prog_n && !sclk && !busy && !pass && !fail && !ready && code == 0,
        "R12 reset state", {prog_n, sclk, busy, pass, fail, ready}, 6'b100000);
    // R10 status follows done after two cycles
    chk(inrst == 1, "R10 status low done", inrst, 1);
    done_force = 1;
    @(negedge clk);
    chk(inrst == 1, "R10 status one cycle", inrst, 1);
    @(negedge clk);
    chk(inrst == 0, "R10 status two cycles", inrst, 0);
    done_force = 0;
    repeat (2) @(negedge clk);
    chk(inrst == 1, "R10 status back", inrst, 1);

    // R1 partial request refused with no pin activity
    begin
      int p0 = pulses, b0 = bitcnt;
      pulse_start(1);
      chk(fail && !busy && code == 2'd3, "R1 unsupported", int'(code), 3);
      repeat (6) @(negedge clk);
      chk(pulses == p0 && bitcnt == b0 && prog_n && !busy, "R1 pins quiet", bitcnt - b0, 0);
    end

    // R3 done stuck high after release
    begin
      int b0 = bitcnt;
      done_force = 1;
      pulse_start(0);
      wait_result();
      chk(fail && code == 2'd1, "R3 done stuck", int'(code), 1);
      chk(last_pw == PULSE_EXP, "R2 pulse width stuck run", last_pw, PULSE_EXP);
      repeat (10) @(negedge clk);
      chk(bitcnt == b0, "R3 no serial clock", bitcnt - b0, 0);
      done_force = 0;
      repeat (4) @(negedge clk);
    end

    // R7 R8 sweep over stream length and done arrival
    for (int n = 1; n <= 3; n++)
      for (int k = 0; k <= 2; k++)
        run_load(n, n * 3 + k, 8 * (n + k), 16'hFFFF, k + 1, 0, 0);
    // R7 done already high during data
    run_load(4, 11, 8, 16'hFFFF, 1, 0, 0);

    // R9 timeout sweep
    begin
      int tv [5] = '{0, 1, PER, PER + 1, 100};
      for (int i = 0; i < 5; i++)
        run_load(2, 20 + i, -1, tv[i], (tv[i] + PER - 1) / PER, 2, 0);
    end

    // R11 start with partial flag while busy is ignored
    run_load(2, 31, 16, 16'hFFFF, 1, 0, 1);

    chk(ready_bad == 0, "R6 ready while clock high", ready_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule